// File: doc/BRIEF.md
# Memory Data-Bus Self-Test Sequencer

This block is a built-in self-test engine for the data lines of a memory port. After a start pulse it writes structured word patterns into a small aligned region, reads every word back, compares it with a value that it regenerates on the fly, and counts the words that differ. The patterns make shorted or open data lines visible. A nibble-ramp pass comes first. A walking-ones pass follows, and a walking-zeros pass ends the test. Each pass repeats as many bursts as the burst-count input requests.

Every mismatch produces a one-cycle error report with the word address, the data seen and the data expected. At the end the sequencer raises `done`. `pass` is high only when no word differed. The memory side is a simple request/ready port with a separate read-data valid flag. Only one read is outstanding at a time.

Top module: `membist_top`

## Requirements
- R1: With a burst count of zero, a start pulse sets the failure count to zero and raises `done` with `pass` high. No memory request is issued.
- R2: The sequencer ignores the low 7 bits of the base address and treats them as zero. Word k of the region (k = 0..63) is at the aligned base plus 8·k. Every request carries an address with bits [2:0] equal to zero.
- R3: The nibble-ramp pass writes words 0..15 once per burst, with word k holding the 4-bit value k in all sixteen nibbles. After all of its write bursts, it reads words 0..15 back once per burst and checks each one.
- R4: The walking-ones pass runs the group sizes N = 1, 2, 3 in that order. For each N and each burst it first writes words 0..63 and then reads words 0..63 back in the same order. Group g (words 16g..16g+15) starts from N contiguous ones at bit 16g. Each later word in the group is the previous word rotated left by one bit, with bit 63 wrapping to bit 0.
- R5: The walking-zeros pass follows the walking-ones pass. It uses the same order and rotation, with every seed bitwise inverted.
- R6: A request holds its address, direction and write data stable until `mem_rdy` is high. A transfer happens on a cycle with both `mem_req` and `mem_rdy` high. `mem_we` high marks a write.
- R7: After a read is accepted, no new request is raised until `mem_rvalid` returns the data.
- R8: For each returned word that differs from its expected value, `err_valid` pulses for one cycle in the cycle after `mem_rvalid`. The pulse carries the address, the observed data and the expected data, and `fail_count` rises by one.
- R9: `done` rises after the last read of the walking-zeros pass and stays high until the next accepted start. `pass` equals `done` with a failure count of zero.
- R10: A start pulse during a run has no effect. A start pulse while idle or done clears the failure count and begins a new run using the current base and burst inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse |
| base_addr | input | 32 | Byte base address of the test region |
| burst_cnt | input | 8 | Bursts per pass; zero skips the test |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdy | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Test finished |
| pass | output | 1 | Test finished without mismatch |
| fail_count | output | 32 | Number of mismatching words |
| err_valid | output | 1 | Error report strobe |
| err_addr | output | 32 | Address of the mismatching word |
| err_obs | output | 64 | Data returned by the memory |
| err_exp | output | 64 | Data the sequencer expected |

## Verification
Suppose the word index, burst counter or group-size counter holds a wrong value. The next request then shows a wrong address or wrong write data within one handshake, and the bench flags it at that write. Suppose instead the pattern is right but the compare path is wrong. That fault stays hidden until a read returns. The error reports, and then the final count and `pass`, drift from the values the bench predicts from its injected bit faults. A wrong sequencer state at the end appears as a `done` that rises early, rises late or never rises, with reads left unconsumed in the bench queues.

// File: rtl/membist_pkg.sv
package membist_pkg;
  typedef enum logic [1:0] {
    PH_INC = 2'd0,
    PH_W1  = 2'd1,
    PH_W0  = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RQ   = 3'd2,
    ST_RW   = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  localparam int unsigned DEF_DW   = 64;
  localparam int unsigned DEF_WPG  = 16;
  localparam int unsigned DEF_MAXN = 3;
  localparam int unsigned DEF_AW   = 32;
  localparam int unsigned DEF_BW   = 8;
  localparam int unsigned DEF_FCW  = 32;
endpackage

// File: rtl/membist_rst_sync.sv
module membist_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/membist_pattern.sv
module membist_pattern
  import membist_pkg::*;
#(
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned WPG  = DEF_WPG,
  parameter int unsigned MAXN = DEF_MAXN,
  parameter int unsigned IDXW = 6,
  parameter int unsigned NBW  = 2
) (
  input  phase_e            phase,
  input  logic [NBW-1:0]    nbits,
  input  logic [IDXW-1:0]   idx,
  output logic [DW-1:0]     data
);
  localparam int unsigned WW   = $clog2(WPG);
  localparam int unsigned GW   = IDXW - WW;
  localparam int unsigned NIBS = DW / 4;

  logic [DW-1:0] ramp_word;
  logic [DW-1:0] mask;
  logic [DW-1:0] seed;
  logic [DW-1:0] walk_word;
  logic [WW-1:0] pos;
  logic [GW-1:0] grp;

  assign pos = idx[WW-1:0];
  assign grp = idx[IDXW-1:WW];

  // ramp: the low nibble of the word index copied into each nibble
  for (genvar n = 0; n < NIBS; n++) begin : g_ramp
    assign ramp_word[4*n +: 4] = idx[3:0];
  end

  always_comb begin
    mask = '0;
    for (int b = 0; b < MAXN; b++) begin
      if (b < int'(nbits)) mask[b] = 1'b1;
    end
    seed      = mask << (int'(grp) * WPG);
    walk_word = (seed << int'(pos)) | (seed >> (DW - int'(pos)));
    if (int'(pos) == 0) walk_word = seed;
  end

  always_comb begin
    unique case (phase)
      PH_INC:  data = ramp_word;
      PH_W0:   data = ~walk_word;
      default: data = walk_word;
    endcase
  end
endmodule

// File: rtl/membist_seq.sv
module membist_seq
  import membist_pkg::*;
#(
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned WPG  = DEF_WPG,
  parameter int unsigned MAXN = DEF_MAXN,
  parameter int unsigned AW   = DEF_AW,
  parameter int unsigned BW   = DEF_BW,
  parameter int unsigned IDXW = 6,
  parameter int unsigned NBW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [BW-1:0]   burst_cnt,
  input  logic            mem_rdy,
  input  logic            mem_rvalid,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [IDXW-1:0] idx,
  output phase_e          phase,
  output logic [NBW-1:0]  nbits,
  output logic            clear,
  output logic            rd_wait,
  output logic            done
);
  localparam int unsigned BYTES     = DW / 8;
  localparam int unsigned OFFB      = $clog2(BYTES);
  localparam int unsigned RAMP_WDS  = 16;
  localparam int unsigned LINEB     = $clog2(RAMP_WDS * BYTES);
  localparam logic [IDXW-1:0] RAMP_LAST = IDXW'(RAMP_WDS - 1);
  localparam logic [IDXW-1:0] WALK_LAST = IDXW'((DW / WPG) * WPG - 1);
  localparam logic [NBW-1:0]  NB_FIRST  = NBW'(1);
  localparam logic [NBW-1:0]  NB_LAST   = NBW'(MAXN);
  localparam logic [AW-1:0]   LINE_MASK = ~AW'((1 << LINEB) - 1);

  state_e          state_q, state_d;
  phase_e          phase_q, phase_d;
  logic [NBW-1:0]  nb_q, nb_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [BW-1:0]   bur_q, bur_d;
  logic [BW-1:0]   nbur_q, nbur_d;
  logic [AW-1:0]   base_q, base_d;
  logic            idx_last, bur_last, accept, start_ok;

  assign idx_last = (idx_q == ((phase_q == PH_INC) ? RAMP_LAST : WALK_LAST));
  assign bur_last = (bur_q == (nbur_q - BW'(1)));
  assign accept   = mem_req & mem_rdy;
  assign start_ok = start & ((state_q == ST_IDLE) | (state_q == ST_DONE));

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    nb_d    = nb_q;
    idx_d   = idx_q;
    bur_d   = bur_q;
    nbur_d  = nbur_q;
    base_d  = base_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          base_d  = base_addr & LINE_MASK;
          nbur_d  = burst_cnt;
          phase_d = PH_INC;
          nb_d    = NB_FIRST;
          idx_d   = '0;
          bur_d   = '0;
          state_d = (burst_cnt == '0) ? ST_DONE : ST_WR;
        end
      end
      ST_WR: begin
        if (accept) begin
          if (!idx_last) begin
            idx_d = idx_q + IDXW'(1);
          end else begin
            idx_d = '0;
            if (phase_q != PH_INC) begin
              state_d = ST_RQ;
            end else if (bur_last) begin
              bur_d   = '0;
              state_d = ST_RQ;
            end else begin
              bur_d = bur_q + BW'(1);
            end
          end
        end
      end
      ST_RQ: begin
        if (accept) state_d = ST_RW;
      end
      ST_RW: begin
        if (mem_rvalid) begin
          state_d = ST_RQ;
          if (!idx_last) begin
            idx_d = idx_q + IDXW'(1);
          end else begin
            idx_d = '0;
            if (phase_q == PH_INC) begin
              if (bur_last) begin
                bur_d   = '0;
                phase_d = PH_W1;
                nb_d    = NB_FIRST;
                state_d = ST_WR;
              end else begin
                bur_d = bur_q + BW'(1);
              end
            end else begin
              state_d = ST_WR;
              if (!bur_last) begin
                bur_d = bur_q + BW'(1);
              end else begin
                bur_d = '0;
                if (nb_q != NB_LAST) begin
                  nb_d = nb_q + NBW'(1);
                end else if (phase_q == PH_W1) begin
                  nb_d    = NB_FIRST;
                  phase_d = PH_W0;
                end else begin
                  state_d = ST_DONE;
                end
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_INC;
      nb_q    <= NB_FIRST;
      idx_q   <= '0;
      bur_q   <= '0;
      nbur_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      nb_q    <= nb_d;
      idx_q   <= idx_d;
      bur_q   <= bur_d;
      if (start_ok) begin
        nbur_q <= nbur_d;
        base_q <= base_d;
      end
    end
  end

  assign mem_req  = (state_q == ST_WR) | (state_q == ST_RQ);
  assign mem_we   = (state_q == ST_WR);
  assign mem_addr = base_q + (AW'(idx_q) << OFFB);
  assign idx      = idx_q;
  assign phase    = phase_q;
  assign nbits    = nb_q;
  assign clear    = start_ok;
  assign rd_wait  = (state_q == ST_RW);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/membist_cmp.sv
module membist_cmp #(
  parameter int unsigned DW  = 64,
  parameter int unsigned AW  = 32,
  parameter int unsigned FCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           rd_wait,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW-1:0]  exp_data,
  input  logic [AW-1:0]  cur_addr,
  output logic [FCW-1:0] fail_count,
  output logic           err_valid,
  output logic [AW-1:0]  err_addr,
  output logic [DW-1:0]  err_obs,
  output logic [DW-1:0]  err_exp
);
  logic           mism;
  logic [FCW-1:0] cnt_q, cnt_d;
  logic           ev_q;
  logic [AW-1:0]  ea_q;
  logic [DW-1:0]  eo_q, ee_q;

  assign mism = rd_wait & mem_rvalid & (mem_rdata != exp_data);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                   cnt_d = '0;
    else if (mism && (~cnt_q != '0)) cnt_d = cnt_q + FCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ev_q  <= 1'b0;
      ea_q  <= '0;
      eo_q  <= '0;
      ee_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ev_q  <= mism;
      if (mism) begin
        ea_q <= cur_addr;
        eo_q <= mem_rdata;
        ee_q <= exp_data;
      end
    end
  end

  assign fail_count = cnt_q;
  assign err_valid  = ev_q;
  assign err_addr   = ea_q;
  assign err_obs    = eo_q;
  assign err_exp    = ee_q;
endmodule

// File: rtl/membist_top.sv
module membist_top
  import membist_pkg::*;
#(
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned WPG  = DEF_WPG,
  parameter int unsigned MAXN = DEF_MAXN,
  parameter int unsigned AW   = DEF_AW,
  parameter int unsigned BW   = DEF_BW,
  parameter int unsigned FCW  = DEF_FCW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  base_addr,
  input  logic [BW-1:0]  burst_cnt,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rdy,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic           pass,
  output logic [FCW-1:0] fail_count,
  output logic           err_valid,
  output logic [AW-1:0]  err_addr,
  output logic [DW-1:0]  err_obs,
  output logic [DW-1:0]  err_exp
);
  localparam int unsigned IDXW = $clog2((DW / WPG) * WPG);
  localparam int unsigned NBW  = $clog2(MAXN + 1);

  logic            rst_n_s;
  logic [IDXW-1:0] idx;
  phase_e          phase;
  logic [NBW-1:0]  nbits;
  logic            clear, rd_wait;
  logic [DW-1:0]   pat;

  membist_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  membist_seq #(
    .DW(DW), .WPG(WPG), .MAXN(MAXN), .AW(AW), .BW(BW), .IDXW(IDXW), .NBW(NBW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start), .base_addr(base_addr),
    .burst_cnt(burst_cnt), .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .idx(idx),
    .phase(phase), .nbits(nbits), .clear(clear), .rd_wait(rd_wait), .done(done)
  );

  membist_pattern #(
    .DW(DW), .WPG(WPG), .MAXN(MAXN), .IDXW(IDXW), .NBW(NBW)
  ) u_pat (
    .phase(phase), .nbits(nbits), .idx(idx), .data(pat)
  );

  membist_cmp #(.DW(DW), .AW(AW), .FCW(FCW)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .clear(clear), .rd_wait(rd_wait),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .exp_data(pat),
    .cur_addr(mem_addr), .fail_count(fail_count), .err_valid(err_valid),
    .err_addr(err_addr), .err_obs(err_obs), .err_exp(err_exp)
  );

  assign mem_wdata = pat;
  assign pass      = done & (fail_count == '0);
endmodule

// File: rtl/membist_chk.sv
module membist_chk #(
  parameter int unsigned DW  = 64,
  parameter int unsigned AW  = 32,
  parameter int unsigned FCW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_rdy,
  input logic           done,
  input logic [FCW-1:0] fail_count,
  input logic           err_valid
);
  localparam int unsigned OFFB = $clog2(DW / 8);

  p_addr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFFB-1:0] == '0));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_one_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rdy) |=> !mem_req);

  p_quiet_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_err_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (fail_count != '0));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_count != $past(fail_count)) |-> ((fail_count == $past(fail_count) + FCW'(1)) || (fail_count == '0)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind membist_top membist_chk #(.DW(DW), .AW(AW), .FCW(FCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .done(done),
  .fail_count(fail_count), .err_valid(err_valid)
);

// File: tb/membist_top_tb.sv
module membist_top_tb;
  typedef struct { logic [31:0] a; logic [63:0] d; } item_t;
  typedef struct { logic [31:0] a; logic [63:0] o; logic [63:0] e; } erep_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [7:0]  burst_cnt = '0;
  logic        mem_req, mem_we, mem_rdy = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        done, pass, err_valid;
  logic [31:0] fail_count, err_addr;
  logic [63:0] err_obs, err_exp;

  int errors = 0, checks = 0, efail = 0, req_seen = 0;
  int fmode = 0, fa = 0, fb = 0;
  item_t wq[$];
  item_t rq[$];
  erep_t eq[$];
  logic [63:0] mem [logic [31:0]];

  always #4 clk = ~clk;

  membist_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .burst_cnt(burst_cnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .pass(pass),
    .fail_count(fail_count), .err_valid(err_valid), .err_addr(err_addr),
    .err_obs(err_obs), .err_exp(err_exp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fault(input logic [63:0] s);
    logic [63:0] o = s;
    case (fmode)
      1: o[fa] = 1'b0;
      2: o[fa] = 1'b1;
      3: begin o[fa] = s[fa] & s[fb]; o[fb] = s[fa] & s[fb]; end
      default: ;
    endcase
    return o;
  endfunction

  function automatic logic [63:0] ramp(input int k);
    logic [63:0] w = '0;
    for (int n = 0; n < 16; n++) w = (w << 4) | 64'(k);
    return w;
  endfunction

  function automatic logic [63:0] rot1(input logic [63:0] x);
    return {x[62:0], x[63]};
  endfunction

  task automatic add_read(input logic [31:0] a, input logic [63:0] d);
    logic [63:0] o;
    rq.push_back('{a, d});
    o = fault(d);
    if (o !== d) begin
      eq.push_back('{a, o, d});
      efail++;
    end
  endtask

  // driver: expected write and read streams from R2..R5
  task automatic build(input logic [31:0] b_in, input int nb);
    logic [31:0] line = b_in & ~32'h7F;
    logic [63:0] d;
    wq.delete(); rq.delete(); eq.delete(); efail = 0;
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 16; k++) wq.push_back('{line + 32'(8*k), ramp(k)});
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 16; k++) add_read(line + 32'(8*k), ramp(k));
    for (int inv = 0; inv < 2; inv++)
      for (int n = 1; n <= 3; n++)
        for (int b = 0; b < nb; b++) begin
          for (int g = 0; g < 4; g++) begin
            d = ((64'd1 << n) - 64'd1) << (16*g);
            if (inv == 1) d = ~d;
            for (int w = 0; w < 16; w++) begin
              wq.push_back('{line + 32'(8*(16*g+w)), d});
              d = rot1(d);
            end
          end
          for (int g = 0; g < 4; g++) begin
            d = ((64'd1 << n) - 64'd1) << (16*g);
            if (inv == 1) d = ~d;
            for (int w = 0; w < 16; w++) begin
              add_read(line + 32'(8*(16*g+w)), d);
              d = rot1(d);
            end
          end
        end
  endtask

  // memory model and scoreboard monitor for requests
  logic [15:0] lfsr = 16'hACE1;
  bit          pend = 0;
  logic [31:0] pend_a;
  int          lat = 0;
  always begin
    logic acc, we_s;
    logic [31:0] a_s;
    logic [63:0] d_s;
    item_t it;
    @(negedge clk);
    acc = mem_req & mem_rdy;
    we_s = mem_we; a_s = mem_addr; d_s = mem_wdata;
    if (mem_req) req_seen++;
    @(posedge clk);
    #1;
    mem_rvalid = 1'b0;
    if (acc && we_s) begin
      mem[a_s] = d_s;
      if (wq.size() == 0) chk(0, "R3", "unexpected write", 64'(a_s), 0);
      else begin
        it = wq.pop_front();
        chk(a_s === it.a, "R2", "write address", 64'(a_s), 64'(it.a));
        chk(d_s === it.d, "R4", "write data", d_s, it.d);
      end
    end else if (acc) begin
      if (rq.size() == 0) chk(0, "R3", "unexpected read", 64'(a_s), 0);
      else begin
        it = rq.pop_front();
        chk(a_s === it.a, "R5", "read address", 64'(a_s), 64'(it.a));
      end
      pend = 1; pend_a = a_s; lat = int'(lfsr[3:2]);
    end else if (pend) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = fault(mem.exists(pend_a) ? mem[pend_a] : 64'd0);
        pend = 0;
      end else lat--;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rdy = (lfsr[1:0] != 2'b00);
  end

  // scoreboard monitor for error reports
  always begin
    erep_t e;
    @(negedge clk);
    if (err_valid === 1'b1) begin
      if (eq.size() == 0) chk(0, "R8", "unexpected error report", 64'(err_addr), 0);
      else begin
        e = eq.pop_front();
        chk(err_addr === e.a, "R8", "error address", 64'(err_addr), 64'(e.a));
        chk(err_obs === e.o, "R8", "observed data", err_obs, e.o);
        chk(err_exp === e.e, "R8", "expected data", err_exp, e.e);
      end
    end
  end

  task automatic pulse_start(input logic [31:0] b, input logic [7:0] n);
    @(negedge clk);
    base_addr = b; burst_cnt = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [31:0] b, input int nb, input int fm,
                     input int x, input int y, input int mid);
    int cyc = 0;
    fmode = fm; fa = x; fb = y;
    build(b, nb);
    pulse_start(b, 8'(nb));
    if (mid > 0) begin
      repeat (mid) @(negedge clk);
      pulse_start(32'h0000_3000, 8'd5);   // R10: ignored while running
      base_addr = b; burst_cnt = 8'(nb);
    end
    while (done !== 1'b1 && cyc < 60000) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R9", "done after run", 64'(done), 1);
    chk(fail_count === 32'(efail), "R8", "failure count", 64'(fail_count), 64'(efail));
    chk(pass === (efail == 0), "R9", "pass flag", 64'(pass), 64'(efail == 0));
    chk(wq.size() == 0 && rq.size() == 0, "R4", "stream fully consumed",
        64'(wq.size() + rq.size()), 0);
    chk(eq.size() == 0, "R8", "all error reports seen", 64'(eq.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0 && err_valid === 1'b0, "R9", "reset outputs",
        {61'd0, done, mem_req, err_valid}, 0);
    chk(fail_count === 0 && pass === 1'b0, "R9", "reset count", 64'(fail_count), 0);

    // R3/R4/R5/R2: clean memory, unaligned base, two bursts
    run(32'h0000_2035, 2, 0, 0, 0, 0);
    // R8: stuck-at-zero on bit 5
    run(32'h0000_0400, 1, 1, 5, 0, 0);
    // R1: zero bursts after a failing run clears the count, no requests
    req_seen = 0;
    pulse_start(32'h0000_0800, 8'd0);
    repeat (4) @(negedge clk);
    chk(done === 1'b1 && pass === 1'b1, "R1", "zero-burst done/pass", {62'd0, done, pass}, 3);
    chk(fail_count === 0, "R1", "zero-burst count", 64'(fail_count), 0);
    chk(req_seen == 0, "R1", "zero-burst requests", 64'(req_seen), 0);
    // R8: bridged bits 17 and 18, three bursts
    run(32'h0000_8000, 3, 3, 17, 18, 0);
    // R10: stuck-at-one on bit 63 with a start pulse mid-run
    run(32'h0001_0040, 1, 2, 63, 0, 150);
    // R9: done holds while idle
    repeat (20) @(negedge clk);
    chk(done === 1'b1 && mem_req === 1'b0, "R9", "done holds", {62'd0, done, mem_req}, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule